// File: doc/BRIEF.md
# Two-Level Address Translation Walker

This block turns a 32-bit virtual address, tagged with a 7-bit address-space identifier, into a physical page frame. It holds one table-base entry per identifier. Software programs an entry in two steps. First it writes an identifier to the select register. Then it writes a data word that carries the base frame of that space's first-level table together with three attribute bits.

A translation request starts a walk. The walker reads one first-level entry and then one second-level entry through a simple single-beat memory read port. It combines the attribute bits found at the three levels and returns one of two results:
- the frame and the effective permissions, or
- a fault code.

Only one walk is in flight at a time. Each result is announced by a one-cycle valid pulse.

Pages are 4 KB. Every table holds 1024 four-byte entries. Every entry keeps a physical address shifted right by 12 in its low bits. Bits 31, 30 and 29 of every entry carry readable, writable and non-secure. A first-level entry also carries a next-level marker in bit 28. An all-zero entry means that nothing is mapped.

Top module: `ptw_top`

## Requirements
- R1: After reset `req_ready` is 1, `rsp_valid` and `mem_rd_en` are 0, and every identifier's base entry is zero. A walk for an identifier that was never programmed therefore reads its first-level entry from byte address `va[31:22]*4`.
- R2: A `cfg_sel_we` write stores `cfg_wdata[6:0]` as the selected identifier. Each later `cfg_data_we` write replaces that identifier's base entry with `cfg_wdata`. The selection persists across several data writes, and the last data write wins.
- R3: The first read is presented with `mem_rd_en` high for exactly one cycle, starting in the cycle after the request is accepted. Its byte address is `base_frame*4096 + va[31:22]*4`, where `base_frame` is the entry's low `PA_BITS-12` bits.
- R4: A first-level entry that is zero, or whose bit 28 is clear, ends the walk with a translation fault (`rsp_fault` = 1) and no second read.
- R5: Otherwise the second read goes to byte address `pde_frame*4096 + va[21:12]*4`. `pde_frame` is the low `PA_BITS-12` bits of the first-level entry.
- R6: A second-level entry of zero ends the walk with a translation fault (`rsp_fault` = 1).
- R7: On success `rsp_frame` equals the low `PA_BITS-12` bits of the second-level entry. Bits between that field and bit 29 are ignored.
- R8: The effective permissions are the AND of bits 31..29 at base, first and second level, reported on `rsp_perm` as {readable, writable, non-secure}. A write without writable, or a read without readable, gives a permission fault (`rsp_fault` = 2). Any fault reports `rsp_frame` = 0 and `rsp_perm` = 0.
- R9: `req_ready` is low from acceptance until the walk ends. Requests presented while busy are ignored and cause no reads.
- R10: `rsp_valid` is high for exactly one cycle per walk, and `req_ready` is high again in the next cycle.
- R11: The base entry is captured when a request is accepted. A data write to the same identifier during the walk affects only later walks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_sel_we | input | 1 | Write identifier select |
| cfg_data_we | input | 1 | Write base entry of selected identifier |
| cfg_wdata | input | 32 | Configuration write data |
| req_valid | input | 1 | Translation request |
| req_asid | input | ASID_W | Address-space identifier of request |
| req_va | input | 32 | Virtual address |
| req_write | input | 1 | 1 = write access, 0 = read access |
| req_ready | output | 1 | Walker idle, request accepted this cycle if valid |
| mem_rd_en | output | 1 | One-cycle memory read request |
| mem_rd_addr | output | PA_BITS | Byte address of the entry to read |
| mem_rd_valid | input | 1 | Read data valid (one cycle) |
| mem_rd_data | input | 32 | Read data |
| rsp_valid | output | 1 | Result pulse |
| rsp_frame | output | PA_BITS-12 | Physical frame number |
| rsp_perm | output | 3 | {readable, writable, non-secure} |
| rsp_fault | output | 2 | 0 none, 1 translation, 2 permission |

## Verification
The assertions assume a well-behaved memory: it raises `mem_rd_valid` for exactly one cycle per read, and only after the read request has gone. The bench's memory model keeps to this. It answers every `mem_rd_en` pulse once, with a random latency of one to three cycles. The assertions also assume that the select and data writes never fall in the same cycle. The bench keeps to this by issuing every configuration write on its own cycle. The bench deliberately holds `req_valid` high during some walks to exercise R9.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  localparam int PAGE_SHIFT = 12;
  localparam int IDX_W      = 10;

  typedef enum logic [1:0] {
    FLT_NONE  = 2'd0,
    FLT_XLATE = 2'd1,
    FLT_PERM  = 2'd2
  } fault_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_DIR_REQ, ST_DIR_WAIT, ST_TBL_REQ, ST_TBL_WAIT, ST_DONE
  } walk_st_e;

  // attribute triple {readable, writable, non-secure} from bits 31..29
  function automatic logic [2:0] attr_of(input logic [31:0] ent);
    return ent[31:29];
  endfunction

  // first-level entry points to a second-level table
  function automatic logic pde_is_table(input logic [31:0] ent);
    return (ent != 32'd0) && ent[28];
  endfunction

  function automatic logic access_ok(input logic [2:0] perm, input logic is_write);
    return is_write ? perm[1] : perm[2];
  endfunction
endpackage

// File: rtl/ptw_base_regs.sv
module ptw_base_regs #(
  parameter int ASID_W  = 7,
  parameter int FRAME_W = 22
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sel_we,
  input  logic               data_we,
  input  logic [31:0]        wdata,
  input  logic [ASID_W-1:0]  rd_asid,
  output logic [FRAME_W-1:0] rd_frame,
  output logic [2:0]         rd_attr
);
  localparam int NUM_ASID = 1 << ASID_W;
  localparam int ENT_W    = FRAME_W + 3;

  logic [ASID_W-1:0] sel_q;
  logic [ENT_W-1:0]  ent_q [NUM_ASID];
  logic [ENT_W-1:0]  wr_ent;
  logic              unused_wbits;

  assign wr_ent       = {wdata[31:29], wdata[FRAME_W-1:0]};
  assign unused_wbits = ^wdata[28:FRAME_W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q <= '0;
      for (int i = 0; i < NUM_ASID; i++) ent_q[i] <= '0;
    end else begin
      if (sel_we)  sel_q        <= wdata[ASID_W-1:0];
      if (data_we) ent_q[sel_q] <= wr_ent;
    end
  end

  assign rd_frame = ent_q[rd_asid][FRAME_W-1:0];
  assign rd_attr  = ent_q[rd_asid][ENT_W-1:FRAME_W];

  assert_sel_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
    sel_we |=> sel_q == $past(wdata[ASID_W-1:0]));
  assert_data_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (data_we && !sel_we) |=> ent_q[sel_q] == $past(wr_ent));
endmodule

// File: rtl/ptw_walk_fsm.sv
module ptw_walk_fsm import ptw_pkg::*; #(
  parameter int PA_BITS = 34
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic [31:12]       req_vpn,
  input  logic               req_write,
  input  logic [PA_BITS-13:0] base_frame,
  input  logic [2:0]         base_attr,
  output logic               req_ready,
  output logic               mem_rd_en,
  output logic [PA_BITS-1:0] mem_rd_addr,
  input  logic               mem_rd_valid,
  input  logic [31:0]        mem_rd_data,
  output logic               rsp_valid,
  output logic [PA_BITS-13:0] rsp_frame,
  output logic [2:0]         rsp_perm,
  output logic [1:0]         rsp_fault
);
  localparam int FRAME_W = PA_BITS - PAGE_SHIFT;

  function automatic logic [PA_BITS-1:0] entry_addr(input logic [FRAME_W-1:0] frame,
                                                    input logic [IDX_W-1:0] idx);
    return {frame, idx, 2'b00};
  endfunction

  walk_st_e           state_q;
  logic [31:12]       vpn_q;
  logic               wr_q;
  logic [FRAME_W-1:0] base_frame_q, pde_frame_q, frame_q;
  logic [2:0]         base_attr_q, pde_attr_q, perm_q;
  fault_e             fault_q;

  // named events for the assertions
  logic       walk_accept, dir_done, dir_miss, tbl_done, tbl_miss, perm_deny;
  logic [2:0] perm_eff;

  assign walk_accept = req_valid && (state_q == ST_IDLE);
  assign dir_done    = (state_q == ST_DIR_WAIT) && mem_rd_valid;
  assign dir_miss    = dir_done && !pde_is_table(mem_rd_data);
  assign tbl_done    = (state_q == ST_TBL_WAIT) && mem_rd_valid;
  assign tbl_miss    = tbl_done && (mem_rd_data == 32'd0);
  assign perm_eff    = base_attr_q & pde_attr_q & attr_of(mem_rd_data);
  assign perm_deny   = tbl_done && !tbl_miss && !access_ok(perm_eff, wr_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q      <= ST_IDLE;
      vpn_q        <= '0;
      wr_q         <= 1'b0;
      base_frame_q <= '0;
      base_attr_q  <= '0;
      pde_frame_q  <= '0;
      pde_attr_q   <= '0;
      frame_q      <= '0;
      perm_q       <= '0;
      fault_q      <= FLT_NONE;
    end else begin
      unique case (state_q)
        ST_IDLE: if (walk_accept) begin
          vpn_q        <= req_vpn;
          wr_q         <= req_write;
          base_frame_q <= base_frame;
          base_attr_q  <= base_attr;
          state_q      <= ST_DIR_REQ;
        end
        ST_DIR_REQ: state_q <= ST_DIR_WAIT;
        ST_DIR_WAIT: if (dir_done) begin
          pde_frame_q <= mem_rd_data[FRAME_W-1:0];
          pde_attr_q  <= attr_of(mem_rd_data);
          if (dir_miss) begin
            frame_q <= '0;
            perm_q  <= '0;
            fault_q <= FLT_XLATE;
            state_q <= ST_DONE;
          end else begin
            state_q <= ST_TBL_REQ;
          end
        end
        ST_TBL_REQ: state_q <= ST_TBL_WAIT;
        ST_TBL_WAIT: if (tbl_done) begin
          state_q <= ST_DONE;
          if (tbl_miss || perm_deny) begin
            frame_q <= '0;
            perm_q  <= '0;
            fault_q <= tbl_miss ? FLT_XLATE : FLT_PERM;
          end else begin
            frame_q <= mem_rd_data[FRAME_W-1:0];
            perm_q  <= perm_eff;
            fault_q <= FLT_NONE;
          end
        end
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready   = (state_q == ST_IDLE);
  assign mem_rd_en   = (state_q == ST_DIR_REQ) || (state_q == ST_TBL_REQ);
  assign mem_rd_addr = (state_q == ST_TBL_REQ) ? entry_addr(pde_frame_q, vpn_q[21:12])
                                               : entry_addr(base_frame_q, vpn_q[31:22]);
  assign rsp_valid   = (state_q == ST_DONE);
  assign rsp_frame   = frame_q;
  assign rsp_perm    = perm_q;
  assign rsp_fault   = fault_q;

  assert_read_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |=> !mem_rd_en);
  assert_first_read_follows_accept_R3: assert property (@(posedge clk) disable iff (!rst_n)
    walk_accept |=> mem_rd_en);
  assert_no_tbl_read_after_miss_R4: assert property (@(posedge clk) disable iff (!rst_n)
    dir_miss |=> (!mem_rd_en && rsp_valid && rsp_fault == FLT_XLATE));
  assert_busy_while_reading_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |-> !req_ready);
  assert_rsp_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> (!rsp_valid && req_ready));
  assert_perm_honoured_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault == FLT_NONE) |-> access_ok(rsp_perm, wr_q));
  assert_fault_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault != FLT_NONE) |-> (rsp_frame == '0 && rsp_perm == '0));
endmodule

// File: rtl/ptw_top.sv
module ptw_top import ptw_pkg::*; #(
  parameter int ASID_W  = 7,
  parameter int PA_BITS = 34
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_sel_we,
  input  logic                cfg_data_we,
  input  logic [31:0]         cfg_wdata,
  input  logic                req_valid,
  input  logic [ASID_W-1:0]   req_asid,
  input  logic [31:0]         req_va,
  input  logic                req_write,
  output logic                req_ready,
  output logic                mem_rd_en,
  output logic [PA_BITS-1:0]  mem_rd_addr,
  input  logic                mem_rd_valid,
  input  logic [31:0]         mem_rd_data,
  output logic                rsp_valid,
  output logic [PA_BITS-13:0] rsp_frame,
  output logic [2:0]          rsp_perm,
  output logic [1:0]          rsp_fault
);
  localparam int FRAME_W = PA_BITS - PAGE_SHIFT;

  logic [FRAME_W-1:0] base_frame;
  logic [2:0]         base_attr;
  logic               unused_offset;

  assign unused_offset = ^req_va[PAGE_SHIFT-1:0];

  ptw_base_regs #(.ASID_W(ASID_W), .FRAME_W(FRAME_W)) u_base (
    .clk      (clk),
    .rst_n    (rst_n),
    .sel_we   (cfg_sel_we),
    .data_we  (cfg_data_we),
    .wdata    (cfg_wdata),
    .rd_asid  (req_asid),
    .rd_frame (base_frame),
    .rd_attr  (base_attr)
  );

  ptw_walk_fsm #(.PA_BITS(PA_BITS)) u_walk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_vpn      (req_va[31:12]),
    .req_write    (req_write),
    .base_frame   (base_frame),
    .base_attr    (base_attr),
    .req_ready    (req_ready),
    .mem_rd_en    (mem_rd_en),
    .mem_rd_addr  (mem_rd_addr),
    .mem_rd_valid (mem_rd_valid),
    .mem_rd_data  (mem_rd_data),
    .rsp_valid    (rsp_valid),
    .rsp_frame    (rsp_frame),
    .rsp_perm     (rsp_perm),
    .rsp_fault    (rsp_fault)
  );
endmodule

// File: tb/test_ptw_top.sv
`timescale 1ns/1ps
module test_ptw_top;
  localparam int ASID_W  = 7;
  localparam int PA_BITS = 34;
  localparam int FRAME_W = PA_BITS - 12;
  localparam logic [31:0] FMASK = (32'd1 << FRAME_W) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_sel_we = 0, cfg_data_we = 0;
  logic [31:0] cfg_wdata = '0;
  logic req_valid = 0, req_write = 0;
  logic [ASID_W-1:0] req_asid = '0;
  logic [31:0] req_va = '0;
  logic req_ready, mem_rd_en, rsp_valid;
  logic [PA_BITS-1:0] mem_rd_addr;
  logic mem_rd_valid = 0;
  logic [31:0] mem_rd_data = '0;
  logic [FRAME_W-1:0] rsp_frame;
  logic [2:0] rsp_perm;
  logic [1:0] rsp_fault;

  always #2 clk = ~clk;

  ptw_top #(.ASID_W(ASID_W), .PA_BITS(PA_BITS)) i_ptw_top (.*);

  int nvec = 0, nfail = 0;
  bit done = 0;
  logic [31:0] mem_img [logic [PA_BITS-1:0]];
  logic [31:0] bench_base [128];

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    nvec++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] peek(input logic [PA_BITS-1:0] a);
    return mem_img.exists(a) ? mem_img[a] : 32'd0;
  endfunction

  // reference walk computed by plain arithmetic on the bench's own state
  task automatic ref_walk(input int asid, input logic [31:0] va, input bit wr,
                          output int nrd, output logic [PA_BITS-1:0] a0, a1,
                          output logic [1:0] flt, output logic [FRAME_W-1:0] frm,
                          output logic [2:0] prm);
    logic [31:0] b, pde, pte;
    logic [2:0] p;
    b = bench_base[asid];
    a0 = PA_BITS'(b & FMASK) * 4096 + PA_BITS'(va >> 22) * 4;
    pde = peek(a0);
    a1 = '0; frm = '0; prm = '0;
    if (pde == 0 || !pde[28]) begin nrd = 1; flt = 2'd1; return; end
    a1 = PA_BITS'(pde & FMASK) * 4096 + PA_BITS'((va >> 12) & 32'h3ff) * 4;
    pte = peek(a1);
    nrd = 2;
    if (pte == 0) begin flt = 2'd1; return; end
    p = b[31:29] & pde[31:29] & pte[31:29];
    if (wr ? !p[1] : !p[2]) begin flt = 2'd2; return; end
    flt = 2'd0; frm = FRAME_W'(pte & FMASK); prm = p;
  endtask

  task automatic cfg_select(input int a);
    @(negedge clk); cfg_sel_we = 1; cfg_wdata = 32'(a);
    @(negedge clk); cfg_sel_we = 0;
  endtask

  task automatic cfg_data(input int a, input logic [31:0] v);
    @(negedge clk); cfg_data_we = 1; cfg_wdata = v;
    @(negedge clk); cfg_data_we = 0;
    bench_base[a] = v;
  endtask

  // one walk; poke holds a second request during the walk (R9),
  // mid_cfg writes a new base for the selected identifier during it (R11)
  task automatic walk(input int asid, input logic [31:0] va, input bit wr,
                      input bit poke, input bit mid_cfg, input logic [31:0] mid_val);
    int nrd, erd, cnt, lat;
    logic [PA_BITS-1:0] a0, a1, ra [2];
    logic [1:0] flt;
    logic [FRAME_W-1:0] frm;
    logic [2:0] prm;
    bit got;
    ref_walk(asid, va, wr, erd, a0, a1, flt, frm, prm);
    nrd = 0; cnt = 0; got = 0; ra[0] = '0; ra[1] = '0;
    @(negedge clk);
    req_valid = 1; req_asid = ASID_W'(asid); req_va = va; req_write = wr;
    for (int c = 0; c < 60; c++) begin
      @(negedge clk);
      mem_rd_valid = 0;
      if (c == 0) begin
        chk("R9 ready low after accept", req_ready, 1'b0);
        chk("R3 first read one cycle after accept", mem_rd_en, 1'b1);
        req_valid = poke;
        req_va = ~va;
        if (mid_cfg) begin cfg_data_we = 1; cfg_wdata = mid_val; end
      end
      if (c == 1) cfg_data_we = 0;
      if (rsp_valid) begin
        got = 1; req_valid = 0;
        chk("R10 rsp_fault", rsp_fault, flt);
        chk("R7 rsp_frame", rsp_frame, frm);
        chk("R8 rsp_perm", rsp_perm, prm);
        break;
      end
      if (cnt > 0) begin
        cnt--;
        if (cnt == 0) begin mem_rd_valid = 1; mem_rd_data = peek(ra[nrd-1]); end
      end
      if (mem_rd_en) begin
        if (nrd < 2) ra[nrd] = mem_rd_addr;
        nrd++;
        lat = $urandom_range(1, 3);
        cnt = lat;
      end
    end
    if (mid_cfg) bench_base[asid] = mid_val;
    chk("R10 response seen", got, 1'b1);
    chk("R4 R9 read count", nrd, erd);
    chk("R3 first-level address", ra[0], a0);
    if (erd == 2) chk("R5 second-level address", ra[1], a1);
    @(negedge clk);
    chk("R10 pulse ends, ready again", {rsp_valid, req_ready}, 2'b01);
  endtask

  initial begin
    #(4 * 150000);
    nfail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    int asids [4];
    int ntbl;
    logic [31:0] v;
    void'($urandom(32'h5eed_0042));
    asids[0] = 3; asids[1] = 77; asids[2] = 127; asids[3] = 0;
    for (int i = 0; i < 128; i++) bench_base[i] = 0;
    ntbl = 0;
    repeat (3) @(negedge clk);
    chk("R1 reset outputs", {req_ready, rsp_valid, mem_rd_en}, 3'b100);
    rst_n = 1;
    @(negedge clk);
    chk("R1 idle after reset", {req_ready, rsp_valid, mem_rd_en}, 3'b100);
    // R1: unprogrammed identifier walks from a zero base
    walk(9, 32'hABCD_E123, 0, 0, 0, 0);
    walk(0, 32'hFFFF_F000, 1, 0, 0, 0);

    // build tables
    for (int k = 0; k < 4; k++) begin
      logic [21:0] dfr;
      dfr = 22'h10000 + 22'(k);
      v = {3'b110 | 3'($urandom_range(0, 7) & (($urandom % 4 == 0) ? 7 : 1)), 7'd0, dfr};
      cfg_select(asids[k]);
      cfg_data(asids[k], v);
      for (int d = 0; d < 17; d++) begin
        int di, kind;
        di = (d == 16) ? 1023 : d;
        kind = (d == 16) ? 2 : $urandom_range(0, 3);
        if (kind == 0) continue;
        if (kind == 1) begin
          mem_img[{dfr, 10'(di), 2'b00}] = 32'hE000_0000 | ($urandom & 32'h0FFF_FFFF & ~32'h1000_0000) | 32'h1;
          continue;
        end
        begin
          logic [21:0] tfr;
          tfr = 22'h20000 + 22'(ntbl);
          ntbl++;
          mem_img[{dfr, 10'(di), 2'b00}] = {($urandom % 5 == 0) ? 3'($urandom) : 3'b111, 1'b1, 6'($urandom), tfr};
          for (int t = 0; t < 9; t++) begin
            int ti;
            ti = (t == 8) ? 1023 : t;
            if ($urandom % 4 == 0) continue;
            v = $urandom;
            if ($urandom % 3 != 0) v[31:30] = 2'b11;
            if (v == 0) v = 1;
            mem_img[{tfr, 10'(ti), 2'b00}] = v;
          end
        end
      end
    end

    // R2: selection persists, last data write wins
    cfg_select(5);
    cfg_data(5, 32'h1234_5678);
    cfg_data(5, {3'b110, 7'd0, 22'h10000});
    cfg_select(6);
    cfg_data(6, 32'hE000_0000 | 32'h10001);
    walk(5, 32'h0000_0000, 0, 0, 0, 0);
    walk(6, 32'h0040_1000, 1, 0, 0, 0);

    // R11: base captured at acceptance; R9: held request ignored
    cfg_select(3);
    walk(3, 32'h0000_0000, 0, 0, 1, {3'b111, 7'd0, 22'h10002});
    walk(3, 32'h0000_0000, 0, 1, 0, 0);
    walk(77, 32'hFFFF_FFFF, 1, 1, 0, 0);

    // R4 R5 R6 R7 R8: random walks over populated and empty regions
    for (int n = 0; n < 400; n++) begin
      int a, di, ti;
      a = ($urandom % 8 == 0) ? 9 : asids[$urandom_range(0, 3)];
      di = ($urandom % 6 == 0) ? 1023 : $urandom_range(0, 17);
      ti = ($urandom % 6 == 0) ? 1023 : $urandom_range(0, 9);
      walk(a, {10'(di), 10'(ti), 12'($urandom)}, 1'($urandom), 1'($urandom % 5 == 0), 0, 0);
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule